// File: doc/BRIEF.md
# Turbo Trellis Forward State-Metric Unit

This block runs the forward recursion of a soft-input decoder for one constituent code of a turbo code. The code has an eight-state trellis. Each step takes three signed log-likelihood ratios for one trellis stage: the channel value of the systematic bit, the a priori value from the other constituent decoder, and the channel value of the parity bit. From these the block computes all eight new forward state metrics in one cycle. Each lane combines the two paths that can enter its state and merges them with a max-star operator built from a maximum plus a small correction table.

After every stage the vector is renormalised against state 0, so the metrics stay inside a 10-bit signed format. On every step, the metric vector used as that stage's input is written to a metric memory at the stage's index. A later backward pass reads it back through a registered read port. A start pulse begins a new code block. It loads the known starting state and rewinds the stage index.

Top module: `fwd_metric_unit`

## Requirements
- R1: During and after synchronous reset, `alpha_vld_o` is 0, `stage_o` is 0, the state-0 metric is 0 and every other metric is -256.
- R2: A `start_i` pulse loads the same values as reset on the next edge and clears `alpha_vld_o`. When `start_i` and `step_i` are high in the same cycle, the step is ignored.
- R3: States are numbered s = 4*r1 + 2*r2 + r3, where r1 is the newest register bit. For input bit u, the feedback bit is a = u^r2^r3, the branch parity is p = a^r1^r3, and the next state is 4*a + 2*r1 + r2. Each new metric merges exactly the two predecessors of its state, one reached with u=0 and one with u=1.
- R4: A candidate is the predecessor metric, plus sys+apr when u=1, plus par when p=1. It is saturated to [-512, 511].
- R5: max-star(a,b) = max(a,b) + c, saturated. c is 3 when |a-b| is 0, 2 when it is 1 to 3, 1 when it is 4 to 9, and 0 when it is 10 or more.
- R6: After every stage, the new state-0 metric is subtracted from all eight new metrics, with saturation. State 0 then reads 0.
- R7: The metrics on `alpha_o` (lane s at bits [10*s+9:10*s]) update on the edge that samples an accepted step. `alpha_vld_o` is high for exactly the cycle after each accepted step. `stage_o` then increments, modulo the memory depth of 64.
- R8: An accepted step at index k writes the metric vector it consumed (the value before the update) to memory address k. `rd_data_o` returns the contents of address `rd_addr_i` one cycle later, and a same-edge write is not yet visible.
- R9: Without an accepted step or start, the metrics and `stage_o` hold and `alpha_vld_o` is 0, whatever the LLR inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a new code block |
| step_i | input | 1 | Process one trellis stage |
| sys_llr_i | input | 6 | Systematic channel LLR, signed |
| apr_llr_i | input | 6 | A priori LLR, signed |
| par_llr_i | input | 6 | Parity channel LLR, signed |
| alpha_o | output | 80 | Current forward metrics, 10-bit signed per state |
| alpha_vld_o | output | 1 | Metrics were updated on the last edge |
| stage_o | output | 6 | Index of the next stage to process |
| rd_addr_i | input | 6 | Metric memory read address |
| rd_data_o | output | 80 | Metric vector read from memory, one cycle latency |

## Verification
The max-star bound assertion takes for granted that both candidates of a lane lie in the metric range. This holds because the candidate adders saturate. The initialisation and hold properties treat `start_i` as dominant and place no ordering limit on the control inputs. The stimulus therefore mixes isolated starts, starts coinciding with steps, idle gaps with moving LLR inputs, and runs longer than the memory depth, so the address wraps. Its LLR values cover zero, small magnitudes near the correction thresholds, and the extremes -32 and +31 that drive the metrics into saturation.

// File: rtl/fwd_metric_pkg.sv
package fwd_metric_pkg;

    localparam int NS         = 8;
    localparam int MW         = 10;
    localparam int LW         = 6;
    localparam int SW         = MW + 3;
    localparam int CORR_LIMIT = 10;
    localparam int M_HI       = (1 << (MW - 1)) - 1;
    localparam int M_LO       = -(1 << (MW - 1));
    localparam int NEG_INIT   = -(1 << (MW - 2));

    typedef logic signed [MW-1:0] metric_t;
    typedef logic signed [LW-1:0] llr_t;
    typedef logic signed [SW-1:0] wide_t;

    typedef struct packed {
        logic [2:0] pred;
        logic       par;
    } branch_t;

    typedef struct packed {
        metric_t c0;
        metric_t c1;
    } cand_pair_t;

    function automatic metric_t sat_m(input wide_t v);
        if (v > wide_t'(M_HI))      return metric_t'(M_HI);
        else if (v < wide_t'(M_LO)) return metric_t'(M_LO);
        else                        return v[MW-1:0];
    endfunction

    function automatic logic [1:0] corr_lut(input wide_t mag);
        if (mag == '0)                    return 2'd3;
        else if (mag < wide_t'(4))        return 2'd2;
        else if (mag < wide_t'(CORR_LIMIT)) return 2'd1;
        else                              return 2'd0;
    endfunction

    function automatic branch_t branch_of(input logic [2:0] ns, input logic u);
        branch_t b;
        logic r3;
        r3     = u ^ ns[2] ^ ns[0];
        b.pred = {ns[1], ns[0], r3};
        b.par  = ns[2] ^ ns[1] ^ r3;
        return b;
    endfunction

    function automatic metric_t init_metric(input int s);
        return (s == 0) ? metric_t'(0) : metric_t'(NEG_INIT);
    endfunction

endpackage

// File: rtl/fwd_branch_unit.sv
module fwd_branch_unit
    import fwd_metric_pkg::*;
#(
    parameter int LANE = 0
) (
    input  metric_t    alpha_i [NS],
    input  llr_t       sys_i,
    input  llr_t       apr_i,
    input  llr_t       par_i,
    output cand_pair_t cand_o
);
    localparam branch_t B0 = branch_of(3'(LANE), 1'b0);
    localparam branch_t B1 = branch_of(3'(LANE), 1'b1);

    wide_t gamma_u;
    wide_t par_w;
    wide_t sum0;
    wide_t sum1;

    always_comb begin
        gamma_u = wide_t'(sys_i) + wide_t'(apr_i);
        par_w   = wide_t'(par_i);
        sum0    = wide_t'(alpha_i[B0.pred]) + (B0.par ? par_w : '0);
        sum1    = wide_t'(alpha_i[B1.pred]) + gamma_u + (B1.par ? par_w : '0);
        cand_o.c0 = sat_m(sum0);
        cand_o.c1 = sat_m(sum1);
    end
endmodule

// File: rtl/fwd_maxstar.sv
module fwd_maxstar
    import fwd_metric_pkg::*;
(
    input  metric_t a_i,
    input  metric_t b_i,
    output metric_t y_o
);
    wide_t      diff;
    wide_t      mag;
    metric_t    mx;
    logic [1:0] cval;

    always_comb begin
        diff = wide_t'(a_i) - wide_t'(b_i);
        mag  = diff[SW-1] ? -diff : diff;
        mx   = diff[SW-1] ? b_i : a_i;
        cval = corr_lut(mag);
        y_o  = sat_m(wide_t'(mx) + wide_t'(cval));
    end
endmodule

// File: rtl/fwd_normalize.sv
module fwd_normalize
    import fwd_metric_pkg::*;
(
    input  metric_t raw_i [NS],
    output metric_t nrm_o [NS]
);
    always_comb begin
        for (int s = 0; s < NS; s++) begin
            nrm_o[s] = sat_m(wide_t'(raw_i[s]) - wide_t'(raw_i[0]));
        end
    end
endmodule

// File: rtl/fwd_metric_mem.sv
module fwd_metric_mem #(
    parameter int DEPTH = 64,
    parameter int W     = 80,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [W-1:0]  wr_data_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [W-1:0]  rd_data_o
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
        rd_data_o <= mem[rd_addr_i];
    end
endmodule

// File: rtl/fwd_metric_unit.sv
module fwd_metric_unit
    import fwd_metric_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             step_i,
    input  logic [LW-1:0]    sys_llr_i,
    input  logic [LW-1:0]    apr_llr_i,
    input  logic [LW-1:0]    par_llr_i,
    output logic [NS*MW-1:0] alpha_o,
    output logic             alpha_vld_o,
    output logic [AW-1:0]    stage_o,
    input  logic [AW-1:0]    rd_addr_i,
    output logic [NS*MW-1:0] rd_data_o
);
    metric_t          alpha_q [NS];
    metric_t          raw     [NS];
    metric_t          nrm     [NS];
    cand_pair_t       cand    [NS];
    logic [AW-1:0]    stage_q;
    logic             vld_q;
    logic             accept;
    logic [NS*MW-1:0] raw_flat;
    logic [NS*MW-1:0] c0_flat;
    logic [NS*MW-1:0] c1_flat;

    assign accept = step_i && !start_i;

    for (genvar g = 0; g < NS; g++) begin : g_lane
        fwd_branch_unit #(.LANE(g)) u_branch (
            .alpha_i (alpha_q),
            .sys_i   (llr_t'(sys_llr_i)),
            .apr_i   (llr_t'(apr_llr_i)),
            .par_i   (llr_t'(par_llr_i)),
            .cand_o  (cand[g])
        );
        fwd_maxstar u_mstar (
            .a_i (cand[g].c0),
            .b_i (cand[g].c1),
            .y_o (raw[g])
        );
        assign alpha_o[g*MW +: MW]  = alpha_q[g];
        assign raw_flat[g*MW +: MW] = raw[g];
        assign c0_flat[g*MW +: MW]  = cand[g].c0;
        assign c1_flat[g*MW +: MW]  = cand[g].c1;
    end

    fwd_normalize u_norm (
        .raw_i (raw),
        .nrm_o (nrm)
    );

    always_ff @(posedge clk) begin
        if (rst || start_i) begin
            for (int s = 0; s < NS; s++) alpha_q[s] <= init_metric(s);
            stage_q <= '0;
            vld_q   <= 1'b0;
        end else if (accept) begin
            for (int s = 0; s < NS; s++) alpha_q[s] <= nrm[s];
            stage_q <= stage_q + 1'b1;
            vld_q   <= 1'b1;
        end else begin
            vld_q   <= 1'b0;
        end
    end

    assign alpha_vld_o = vld_q;
    assign stage_o     = stage_q;

    fwd_metric_mem #(.DEPTH(DEPTH), .W(NS*MW)) u_mem (
        .clk       (clk),
        .wr_en_i   (accept),
        .wr_addr_i (stage_q),
        .wr_data_i (alpha_o),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o)
    );
endmodule

// File: rtl/fwd_metric_chk.sv
module fwd_metric_chk
    import fwd_metric_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             step_i,
    input logic [NS*MW-1:0] alpha_o,
    input logic             alpha_vld_o,
    input logic [AW-1:0]    stage_o,
    input logic [NS*MW-1:0] raw_flat,
    input logic [NS*MW-1:0] c0_flat,
    input logic [NS*MW-1:0] c1_flat
);
    // R6
    norm_zero_chk: assert property (@(posedge clk) disable iff (rst)
        alpha_vld_o |-> (alpha_o[MW-1:0] == '0));

    // R2
    start_init_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (alpha_o[MW-1:0] == '0) && (stage_o == '0) && !alpha_vld_o);

    // R7
    step_adv_chk: assert property (@(posedge clk) disable iff (rst)
        (step_i && !start_i) |=> alpha_vld_o && (stage_o == AW'($past(stage_o) + 1'b1)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!step_i && !start_i) |=> $stable(alpha_o) && $stable(stage_o) && !alpha_vld_o);

    for (genvar g = 0; g < NS; g++) begin : g_lane
        metric_t c0, c1, rw, mx, al;
        assign c0 = metric_t'(c0_flat[g*MW +: MW]);
        assign c1 = metric_t'(c1_flat[g*MW +: MW]);
        assign rw = metric_t'(raw_flat[g*MW +: MW]);
        assign al = metric_t'(alpha_o[g*MW +: MW]);
        assign mx = (c0 > c1) ? c0 : c1;

        // R5
        maxstar_bound_chk: assert property (@(posedge clk) disable iff (rst)
            step_i |-> (rw >= mx) && (wide_t'(rw) <= wide_t'(mx) + wide_t'(3)));

        if (g != 0) begin : g_init
            // R2
            lane_init_chk: assert property (@(posedge clk) disable iff (rst)
                start_i |=> (al == metric_t'(NEG_INIT)));
        end
    end
endmodule

bind fwd_metric_unit fwd_metric_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .step_i      (step_i),
    .alpha_o     (alpha_o),
    .alpha_vld_o (alpha_vld_o),
    .stage_o     (stage_o),
    .raw_flat    (raw_flat),
    .c0_flat     (c0_flat),
    .c1_flat     (c1_flat)
);

// File: tb/fwd_metric_unit_tb.sv
module fwd_metric_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        step_i = 1'b0;
    logic [5:0]  sys_llr_i = '0;
    logic [5:0]  apr_llr_i = '0;
    logic [5:0]  par_llr_i = '0;
    logic [79:0] alpha_o;
    logic        alpha_vld_o;
    logic [5:0]  stage_o;
    logic [5:0]  rd_addr_i = '0;
    logic [79:0] rd_data_o;

    always #4 clk = ~clk;

    fwd_metric_unit u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .step_i(step_i),
        .sys_llr_i(sys_llr_i), .apr_llr_i(apr_llr_i), .par_llr_i(par_llr_i),
        .alpha_o(alpha_o), .alpha_vld_o(alpha_vld_o), .stage_o(stage_o),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
    );

    int n_checks = 0;
    int n_fail   = 0;

    int m_alpha [8];
    int m_mem   [64][8];
    bit m_wr    [64];
    int m_stage;
    bit m_vld;

    function automatic int sat(int v);
        if (v > 511)  return 511;
        if (v < -512) return -512;
        return v;
    endfunction

    function automatic int mstar(int a, int b);
        int d = (a > b) ? a - b : b - a;
        int m = (a > b) ? a : b;
        int c;
        if (d == 0)      c = 3;
        else if (d < 4)  c = 2;
        else if (d < 10) c = 1;
        else             c = 0;
        return sat(m + c);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_init();
        for (int s = 0; s < 8; s++) m_alpha[s] = (s == 0) ? 0 : -256;
        m_stage = 0;
        m_vld   = 1'b0;
    endtask

    task automatic model_step(int sys, int apr, int par);
        int c0 [8];
        int c1 [8];
        int rw [8];
        for (int s = 0; s < 8; s++) m_mem[m_stage][s] = m_alpha[s];
        m_wr[m_stage] = 1'b1;
        for (int s = 0; s < 8; s++) begin
            for (int u = 0; u < 2; u++) begin
                int r1 = (s >> 2) & 1;
                int r2 = (s >> 1) & 1;
                int r3 = s & 1;
                int a  = u ^ r2 ^ r3;
                int p  = a ^ r1 ^ r3;
                int ns = (a << 2) | (r1 << 1) | r2;
                int c  = sat(m_alpha[s] + (u == 1 ? sys + apr : 0) + (p == 1 ? par : 0));
                if (u == 0) c0[ns] = c; else c1[ns] = c;
            end
        end
        for (int s = 0; s < 8; s++) rw[s] = mstar(c0[s], c1[s]);
        for (int s = 0; s < 8; s++) m_alpha[s] = sat(rw[s] - rw[0]);
        m_stage = (m_stage + 1) % 64;
        m_vld   = 1'b1;
    endtask

    task automatic compare_state(string req);
        chk(alpha_vld_o == m_vld, "R7", "alpha_vld_o", int'(alpha_vld_o), int'(m_vld));
        chk(int'(stage_o) == m_stage, "R7", "stage_o", int'(stage_o), m_stage);
        for (int s = 0; s < 8; s++) begin
            int act = $signed(alpha_o[s*10 +: 10]);
            chk(act == m_alpha[s], req, $sformatf("alpha lane %0d", s), act, m_alpha[s]);
        end
    endtask

    task automatic cycle(bit st, bit sp, int sys, int apr, int par, int ra, string req);
        int  exp_rd [8];
        bit  rd_ok;
        @(negedge clk);
        start_i   = st;
        step_i    = sp;
        sys_llr_i = 6'(sys);
        apr_llr_i = 6'(apr);
        par_llr_i = 6'(par);
        rd_addr_i = 6'(ra);
        @(posedge clk);
        rd_ok = m_wr[ra];
        for (int s = 0; s < 8; s++) exp_rd[s] = m_mem[ra][s];
        if (st)      model_init();
        else if (sp) model_step(sys, apr, par);
        else         m_vld = 1'b0;
        #1;
        compare_state(req);
        if (rd_ok) begin
            for (int s = 0; s < 8; s++) begin
                int act = $signed(rd_data_o[s*10 +: 10]);
                chk(act == exp_rd[s], "R8", $sformatf("rd lane %0d addr %0d", s, ra), act, exp_rd[s]);
            end
        end
    endtask

    function automatic int rl(int lo, int hi);
        return lo + int'($urandom_range(0, hi - lo));
    endfunction

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) m_wr[i] = 1'b0;
        model_init();
        repeat (3) @(posedge clk);
        #1;
        compare_state("R1");
        @(negedge clk);
        rst = 1'b0;
        #1;
        compare_state("R1");

        // R3: zero inputs, then systematic-only patterns
        for (int i = 0; i < 4; i++) cycle(0, 1, 0, 0, 0, 0, "R3");
        for (int i = 0; i < 6; i++) cycle(0, 1, (i % 2) ? 12 : -9, 0, 0, i, "R3");
        for (int i = 0; i < 6; i++) cycle(0, 1, 0, (i < 3) ? 7 : -7, 0, i, "R3");

        // R4: parity-only and extreme values driving saturation
        cycle(1, 0, 0, 0, 0, 0, "R2");
        for (int i = 0; i < 8; i++) cycle(0, 1, 0, 0, (i % 3 == 0) ? 20 : -15, i, "R4");
        for (int i = 0; i < 16; i++) cycle(0, 1, -32, -32, (i % 2) ? 31 : -32, i, "R4");
        for (int i = 0; i < 16; i++) cycle(0, 1, 31, 31, 31, i, "R4");

        // R5: small magnitudes near correction thresholds
        cycle(1, 0, 0, 0, 0, 0, "R2");
        for (int i = 0; i < 30; i++) cycle(0, 1, rl(-3, 3), rl(-3, 3), rl(-5, 5), rl(0, 29), "R5");

        // R6: full-range random inputs
        for (int i = 0; i < 40; i++) cycle(0, 1, rl(-32, 31), rl(-32, 31), rl(-32, 31), rl(0, 63), "R6");

        // R9: idle cycles with moving inputs
        for (int i = 0; i < 10; i++) cycle(0, 0, rl(-32, 31), rl(-32, 31), rl(-32, 31), rl(0, 63), "R9");

        // R2: start mid-block, start together with step
        cycle(1, 1, 25, 25, 25, 0, "R2");
        cycle(0, 1, 5, -4, 9, 0, "R2");
        cycle(1, 1, -20, 3, 14, 0, "R2");
        cycle(0, 0, 0, 0, 0, 0, "R2");

        // R8: long run wrapping the memory, mixed with idle gaps, then a read sweep
        for (int i = 0; i < 80; i++)
            cycle(0, (i % 5) != 4, rl(-32, 31), rl(-32, 31), rl(-32, 31), rl(0, 63), "R8");
        for (int a = 0; a < 64; a++) cycle(0, 0, 0, 0, 0, a, "R8");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule